// File: doc/BRIEF.md
# Three-Wire Serial Register Port for a Command Mailbox

This block is a slave on a three-wire serial bus made of a serial clock, a single data line that changes direction, and an active-low frame enable. It lets an external controller write a command word and its argument words, and read back response words, as 16-bit registers. All three bus lines are sampled by a fast system clock. The data line is split into an input, an output and an output enable, and the pad is built outside this block.

Each frame opens when the enable goes low. The controller first shifts in a 9-bit control word, most significant bit first. The control word holds a 3-bit device prefix that must read 101b, then a direction bit, then a 5-bit register index. A write frame carries 16 more bits. A read frame leaves the line idle for half a serial clock, and then the slave drives 16 bits. A write takes effect only when the frame is properly closed: the enable goes high and one further serial clock pulse is given. A write to the command register then raises a one-cycle launch strobe to the command engine, which sits outside this block and also fills in the response words.

Top module: `threewire_mailbox_port`

## Requirements
- R1: A frame starts only when the enable falls. Serial clock pulses while the enable is high and no frame is open have no effect. Control and write bits are sampled on serial clock rising edges, most significant bit first.
- R2: A control word whose top three bits are not 101b is ignored. For the rest of that frame the data output enable stays low, and any data bits that follow change no register.
- R3: In a write frame, the 16 bits after the control word form the written word, most significant bit first.
- R4: In a read frame, the output enable is low for the half cycle after the control word. It rises at the next serial clock rising edge, where bit 15 is presented. Each following rising edge presents the next lower bit. The enable drops at the rising edge after bit 0, or when the frame enable goes high.
- R5: A complete write is committed only when the frame closes: the enable goes high, then the serial clock rises and falls once. If the enable falls again before that closing pulse, the pending write is discarded.
- R6: Register indices 1, 2 and 3 (full addresses 0xA1 to 0xA3) are argument registers. They can be read back, and together they drive the argument output, with index 1 in the low 16 bits.
- R7: Register index 0 (address 0xA0) is the command register. Committing a write to it updates the command output and raises the launch strobe for exactly one system clock.
- R8: Register indices 8 to 15 (addresses 0xA8 to 0xAF) read response word index-8 from the response input, where word k sits at bits 16k+15 down to 16k. Writes to these indices are ignored.
- R9: Reads of any other register index return 0x0000.
- R10: After reset the command and argument outputs are zero, and the strobe and the data output enable are low.
- R11: A write frame closed before all 16 data bits have arrived changes no register and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bus clock |
| sen_n_i | input | 1 | Active-low frame enable |
| sdio_i | input | 1 | Serial data from the pad |
| sdio_o | output | 1 | Serial data to the pad |
| sdio_oe | output | 1 | Pad output enable for serial data |
| cmd_o | output | 16 | Command register contents |
| arg_o | output | 48 | Argument registers, index 1 in bits 15:0 |
| cmd_go | output | 1 | One-cycle command launch strobe |
| resp_i | input | 128 | Response words, word k in bits 16k+15:16k |

## Verification
The closing edge of a frame and the falling enable of the next frame can land together. So can the closing of a command write and the snapshot taken for a read of the command register straight after it. The bench drops the enable low between the enable rising and the closing pulse. It then judges that the command output and the strobe count stay unchanged. The bench also reads the command register in the frame right after a launch, and judges that the new word is returned.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [3:0] {
        FS_IDLE,
        FS_CTRL,
        FS_WDATA,
        FS_WFULL,
        FS_TURN,
        FS_RDATA,
        FS_DRAIN,
        FS_SKIP,
        FS_CLOSE_HI,
        FS_CLOSE_LO
    } frame_state_e;

endpackage

// File: rtl/tw_input_sync.sv
module tw_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sen_n_i,
    input  logic sdio_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sen_fall,
    output logic sen_rise,
    output logic sen_low,
    output logic sdio_s
);

    typedef struct packed {
        logic [STAGES-1:0] sclk;
        logic [STAGES-1:0] sen;
        logic [STAGES-1:0] sdio;
        logic              sclk_prev;
        logic              sen_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    logic sclk_s;
    logic sen_s;

    assign sclk_s = sync_q.sclk[STAGES-1];
    assign sen_s  = sync_q.sen[STAGES-1];

    always_comb begin
        sync_d           = sync_q;
        sync_d.sclk      = {sync_q.sclk[STAGES-2:0], sclk_i};
        sync_d.sen       = {sync_q.sen[STAGES-2:0], sen_n_i};
        sync_d.sdio      = {sync_q.sdio[STAGES-2:0], sdio_i};
        sync_d.sclk_prev = sclk_s;
        sync_d.sen_prev  = sen_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.sclk      <= '0;
            sync_q.sen       <= '1;
            sync_q.sdio      <= '0;
            sync_q.sclk_prev <= 1'b0;
            sync_q.sen_prev  <= 1'b1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sclk_rise = sclk_s & ~sync_q.sclk_prev;
    assign sclk_fall = ~sclk_s & sync_q.sclk_prev;
    assign sen_fall  = ~sen_s & sync_q.sen_prev;
    assign sen_rise  = sen_s & ~sync_q.sen_prev;
    assign sen_low   = ~sen_s;
    assign sdio_s    = sync_q.sdio[STAGES-1];

endmodule

// File: rtl/tw_frame.sv
module tw_frame
    import tw_pkg::*;
#(
    parameter int          DATA_W = 16,
    parameter int          ADDR_W = 5,
    parameter int          ID_W   = 3,
    parameter logic [ID_W-1:0] DEV_ID = 3'b101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sen_fall,
    input  logic              sen_rise,
    input  logic              sdio_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdio_o,
    output logic              sdio_oe
);

    localparam int CTRL_W = ID_W + 1 + ADDR_W;
    localparam int MAX_W  = (DATA_W > CTRL_W) ? DATA_W : CTRL_W;
    localparam int CNT_W  = $clog2(MAX_W + 1);

    typedef struct packed {
        frame_state_e      state;
        logic [CNT_W-1:0]  cnt;
        logic [CTRL_W-1:0] ctrl_sh;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data_sh;
        logic              pend;
        logic              sdio;
        logic              commit;
    } frame_t;

    frame_t fr_d, fr_q;

    logic [CTRL_W-1:0] ctrl_word;
    logic              in_frame;

    assign ctrl_word = {fr_q.ctrl_sh[CTRL_W-2:0], sdio_s};
    assign in_frame  = (fr_q.state != FS_IDLE) &&
                       (fr_q.state != FS_CLOSE_HI) &&
                       (fr_q.state != FS_CLOSE_LO);

    always_comb begin
        fr_d        = fr_q;
        fr_d.commit = 1'b0;
        if (sen_fall) begin
            fr_d.state = FS_CTRL;
            fr_d.cnt   = '0;
            fr_d.pend  = 1'b0;
            fr_d.sdio  = 1'b0;
        end else if (sen_rise && in_frame) begin
            fr_d.state = FS_CLOSE_HI;
            fr_d.sdio  = 1'b0;
        end else begin
            case (fr_q.state)
                FS_CTRL: begin
                    if (sclk_rise) begin
                        fr_d.ctrl_sh = ctrl_word;
                        fr_d.cnt     = fr_q.cnt + 1'b1;
                        if (fr_q.cnt == CNT_W'(CTRL_W - 1)) begin
                            fr_d.cnt  = '0;
                            fr_d.addr = ctrl_word[ADDR_W-1:0];
                            if (ctrl_word[CTRL_W-1 -: ID_W] != DEV_ID) begin
                                fr_d.state = FS_SKIP;
                            end else if (ctrl_word[ADDR_W]) begin
                                fr_d.state = FS_TURN;
                            end else begin
                                fr_d.state = FS_WDATA;
                            end
                        end
                    end
                end
                FS_WDATA: begin
                    if (sclk_rise) begin
                        fr_d.data_sh = {fr_q.data_sh[DATA_W-2:0], sdio_s};
                        fr_d.cnt     = fr_q.cnt + 1'b1;
                        if (fr_q.cnt == CNT_W'(DATA_W - 1)) begin
                            fr_d.state = FS_WFULL;
                            fr_d.pend  = 1'b1;
                        end
                    end
                end
                FS_TURN: begin
                    if (sclk_rise) begin
                        fr_d.state   = FS_RDATA;
                        fr_d.sdio    = rd_data[DATA_W-1];
                        fr_d.data_sh = {rd_data[DATA_W-2:0], 1'b0};
                        fr_d.cnt     = CNT_W'(1);
                    end
                end
                FS_RDATA: begin
                    if (sclk_rise) begin
                        if (fr_q.cnt == CNT_W'(DATA_W)) begin
                            fr_d.state = FS_DRAIN;
                            fr_d.sdio  = 1'b0;
                        end else begin
                            fr_d.sdio    = fr_q.data_sh[DATA_W-1];
                            fr_d.data_sh = {fr_q.data_sh[DATA_W-2:0], 1'b0};
                            fr_d.cnt     = fr_q.cnt + 1'b1;
                        end
                    end
                end
                FS_CLOSE_HI: begin
                    if (sclk_rise) begin
                        fr_d.state = FS_CLOSE_LO;
                    end
                end
                FS_CLOSE_LO: begin
                    if (sclk_fall) begin
                        fr_d.state  = FS_IDLE;
                        fr_d.commit = fr_q.pend;
                        fr_d.pend   = 1'b0;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q.state   <= FS_IDLE;
            fr_q.cnt     <= '0;
            fr_q.ctrl_sh <= '0;
            fr_q.addr    <= '0;
            fr_q.data_sh <= '0;
            fr_q.pend    <= 1'b0;
            fr_q.sdio    <= 1'b0;
            fr_q.commit  <= 1'b0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign reg_addr = fr_q.addr;
    assign wr_en    = fr_q.commit;
    assign wr_data  = fr_q.data_sh;
    assign sdio_o   = fr_q.sdio;
    assign sdio_oe  = (fr_q.state == FS_RDATA);

endmodule

// File: rtl/tw_mailbox.sv
module tw_mailbox #(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 5,
    parameter int N_ARG     = 3,
    parameter int N_RESP    = 8,
    parameter int CMD_IDX   = 0,
    parameter int ARG_BASE  = 1,
    parameter int RESP_BASE = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [N_RESP*DATA_W-1:0] resp_i,
    output logic [DATA_W-1:0]        rd_data,
    output logic [DATA_W-1:0]        cmd_o,
    output logic [N_ARG*DATA_W-1:0]  arg_o,
    output logic                     cmd_go
);

    typedef struct packed {
        logic [DATA_W-1:0]            cmd;
        logic [N_ARG-1:0][DATA_W-1:0] args;
        logic                         go;
    } mbox_t;

    mbox_t mb_d, mb_q;

    always_comb begin
        mb_d    = mb_q;
        mb_d.go = 1'b0;
        if (wr_en) begin
            if (reg_addr == ADDR_W'(CMD_IDX)) begin
                mb_d.cmd = wr_data;
                mb_d.go  = 1'b1;
            end
            for (int i = 0; i < N_ARG; i++) begin
                if (reg_addr == ADDR_W'(ARG_BASE + i)) begin
                    mb_d.args[i] = wr_data;
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (reg_addr == ADDR_W'(CMD_IDX)) begin
            rd_data = mb_q.cmd;
        end
        for (int i = 0; i < N_ARG; i++) begin
            if (reg_addr == ADDR_W'(ARG_BASE + i)) begin
                rd_data = mb_q.args[i];
            end
        end
        for (int j = 0; j < N_RESP; j++) begin
            if (reg_addr == ADDR_W'(RESP_BASE + j)) begin
                rd_data = resp_i[j*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mb_q <= '0;
        end else begin
            mb_q <= mb_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < N_ARG; g++) begin : g_arg_out
            assign arg_o[g*DATA_W +: DATA_W] = mb_q.args[g];
        end
    endgenerate

    assign cmd_o  = mb_q.cmd;
    assign cmd_go = mb_q.go;

endmodule

// File: rtl/threewire_mailbox_port.sv
module threewire_mailbox_port #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 5,
    parameter int ID_W        = 3,
    parameter logic [ID_W-1:0] DEV_ID = 3'b101,
    parameter int N_ARG       = 3,
    parameter int N_RESP      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk_i,
    input  logic                     sen_n_i,
    input  logic                     sdio_i,
    output logic                     sdio_o,
    output logic                     sdio_oe,
    output logic [DATA_W-1:0]        cmd_o,
    output logic [N_ARG*DATA_W-1:0]  arg_o,
    output logic                     cmd_go,
    input  logic [N_RESP*DATA_W-1:0] resp_i
);

    logic              sclk_rise;
    logic              sclk_fall;
    logic              sen_fall;
    logic              sen_rise;
    logic              sen_low;
    logic              sdio_s;
    logic [ADDR_W-1:0] reg_addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    tw_input_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (sclk_i),
        .sen_n_i  (sen_n_i),
        .sdio_i   (sdio_i),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .sen_fall (sen_fall),
        .sen_rise (sen_rise),
        .sen_low  (sen_low),
        .sdio_s   (sdio_s)
    );

    tw_frame #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .ID_W  (ID_W),
        .DEV_ID(DEV_ID)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .sen_fall (sen_fall),
        .sen_rise (sen_rise),
        .sdio_s   (sdio_s),
        .rd_data  (rd_data),
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sdio_o   (sdio_o),
        .sdio_oe  (sdio_oe)
    );

    tw_mailbox #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .N_ARG (N_ARG),
        .N_RESP(N_RESP)
    ) u_mbox (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .reg_addr(reg_addr),
        .wr_data (wr_data),
        .resp_i  (resp_i),
        .rd_data (rd_data),
        .cmd_o   (cmd_o),
        .arg_o   (arg_o),
        .cmd_go  (cmd_go)
    );

endmodule

// File: rtl/tw_port_checker.sv
module tw_port_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sdio_oe,
    input logic              sdio_o,
    input logic              sen_low,
    input logic              sclk_rise,
    input logic              wr_en,
    input logic              cmd_go,
    input logic [DATA_W-1:0] cmd_o
);

    AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> !cmd_go); // R7

    AST_GO_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> $past(wr_en)); // R7

    AST_CMD_HOLDS_UNTIL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cmd_o)); // R5

    AST_DRIVE_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> $past(sen_low)); // R4

    AST_DATA_MOVES_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_oe && $past(sdio_oe) && !$past(sclk_rise)) |-> $stable(sdio_o)); // R4

endmodule

bind threewire_mailbox_port tw_port_checker #(
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sdio_oe  (sdio_oe),
    .sdio_o   (sdio_o),
    .sen_low  (sen_low),
    .sclk_rise(sclk_rise),
    .wr_en    (wr_en),
    .cmd_go   (cmd_go),
    .cmd_o    (cmd_o)
);

// File: tb/threewire_mailbox_port_bench.sv
`timescale 1ns/1ps
module threewire_mailbox_port_bench;

    localparam int HP = 8;
    localparam int NV = 18;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         sclk;
    logic         sen_n;
    logic         sdio;
    logic         sdio_o;
    logic         sdio_oe;
    logic [15:0]  cmd_o;
    logic [47:0]  arg_o;
    logic         cmd_go;
    logic [127:0] resp;

    int checks = 0;
    int fails  = 0;
    int go_cnt = 0;
    bit done   = 1'b0;

    // {rd, prefix, index, write word, expected read word}
    localparam logic [40:0] VEC [NV] = '{
        {1'b0, 3'b101, 5'd1,  16'h1234, 16'h0000},
        {1'b0, 3'b101, 5'd2,  16'hABCD, 16'h0000},
        {1'b0, 3'b101, 5'd3,  16'h8001, 16'h0000},
        {1'b1, 3'b101, 5'd1,  16'h0000, 16'h1234},
        {1'b1, 3'b101, 5'd2,  16'h0000, 16'hABCD},
        {1'b1, 3'b101, 5'd3,  16'h0000, 16'h8001},
        {1'b1, 3'b101, 5'd8,  16'h0000, 16'hC000},
        {1'b1, 3'b101, 5'd15, 16'h0000, 16'hC777},
        {1'b1, 3'b101, 5'd11, 16'h0000, 16'hC333},
        {1'b1, 3'b101, 5'd5,  16'h0000, 16'h0000},
        {1'b1, 3'b101, 5'd20, 16'h0000, 16'h0000},
        {1'b0, 3'b101, 5'd9,  16'hFFFF, 16'h0000},
        {1'b1, 3'b101, 5'd9,  16'h0000, 16'hC111},
        {1'b0, 3'b100, 5'd1,  16'h5555, 16'h0000},
        {1'b1, 3'b101, 5'd1,  16'h0000, 16'h1234},
        {1'b1, 3'b001, 5'd8,  16'h0000, 16'h0000},
        {1'b0, 3'b101, 5'd0,  16'h0042, 16'h0000},
        {1'b1, 3'b101, 5'd0,  16'h0000, 16'h0042}
    };

    threewire_mailbox_port u_threewire_mailbox_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk),
        .sen_n_i(sen_n),
        .sdio_i (sdio),
        .sdio_o (sdio_o),
        .sdio_oe(sdio_oe),
        .cmd_o  (cmd_o),
        .arg_o  (arg_o),
        .cmd_go (cmd_go),
        .resp_i (resp)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (cmd_go) go_cnt++;
    end

    task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdio = b;
        hp();
        sclk = 1'b1;
        hp();
        sclk = 1'b0;
    endtask

    task automatic send_ctrl(input logic rd, input logic [2:0] pfx, input logic [4:0] idx);
        sen_n = 1'b0;
        hp();
        for (int i = 2; i >= 0; i--) send_bit(pfx[i]);
        send_bit(rd);
        for (int i = 4; i >= 0; i--) send_bit(idx[i]);
    endtask

    task automatic write_bits(input logic [15:0] w, input int n);
        for (int i = 15; i > 15 - n; i--) send_bit(w[i]);
    endtask

    task automatic read_bits(output logic [15:0] d, output int oe_n, output logic oe_turn);
        d = '0;
        oe_n = 0;
        sdio = 1'b0;
        hp();
        oe_turn = sdio_oe;
        for (int i = 15; i >= 0; i--) begin
            sclk = 1'b1;
            hp();
            d[i] = sdio_o;
            if (sdio_oe) oe_n++;
            sclk = 1'b0;
            hp();
        end
    endtask

    task automatic close_frame();
        sen_n = 1'b1;
        sdio = 1'b0;
        hp();
        sclk = 1'b1;
        hp();
        sclk = 1'b0;
        hp();
    endtask

    function automatic string tag_of(input logic [2:0] pfx, input logic [4:0] idx);
        if (pfx != 3'b101) return "R2";
        if (idx == 5'd0) return "R7";
        if (idx >= 5'd1 && idx <= 5'd3) return "R6";
        if (idx >= 5'd8 && idx <= 5'd15) return "R8";
        return "R9";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int          oe_n;
        logic        oe_t;
        int          g0;
        for (int k = 0; k < 8; k++) resp[k*16 +: 16] = 16'hC000 | (16'(k) * 16'h0111);
        rst_n = 1'b0;
        sclk  = 1'b0;
        sen_n = 1'b1;
        sdio  = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        hp();

        // R10 reset state
        check(cmd_o == 16'h0, "R10 cmd", 48'(cmd_o), 48'h0);
        check(arg_o == 48'h0, "R10 args", arg_o, 48'h0);
        check(sdio_oe == 1'b0 && go_cnt == 0, "R10 oe/strobe", 48'({sdio_oe, go_cnt[7:0]}), 48'h0);

        // R1: stray clocks with enable high before any frame
        sdio = 1'b1;
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; hp(); sclk = 1'b0; hp();
        end

        for (int v = 0; v < NV; v++) begin
            logic        rd;
            logic [2:0]  pfx;
            logic [4:0]  idx;
            logic [15:0] wd;
            logic [15:0] ex;
            {rd, pfx, idx, wd, ex} = VEC[v];
            g0 = go_cnt;
            send_ctrl(rd, pfx, idx);
            if (rd) begin
                read_bits(d, oe_n, oe_t);
                close_frame();
                if (pfx == 3'b101)
                    check(d == ex && oe_n == 16 && !oe_t, tag_of(pfx, idx),
                          48'({oe_t, 8'(oe_n), d}), 48'({1'b0, 8'd16, ex}));
                else
                    check(oe_n == 0 && !oe_t, "R2 no drive", 48'({oe_t, 8'(oe_n)}), 48'h0);
            end else begin
                write_bits(wd, 16);
                close_frame();
                check(go_cnt - g0 == ((pfx == 3'b101 && idx == 5'd0) ? 1 : 0), tag_of(pfx, idx),
                      48'(go_cnt - g0), 48'((pfx == 3'b101 && idx == 5'd0) ? 1 : 0));
            end
        end

        // R6 argument outputs, R7 command output
        check(arg_o == {16'h8001, 16'hABCD, 16'h1234}, "R6 arg_o", arg_o, {16'h8001, 16'hABCD, 16'h1234});
        check(cmd_o == 16'h0042, "R7 cmd_o", 48'(cmd_o), 48'h0042);

        // R3 MSB-first data word
        send_ctrl(1'b0, 3'b101, 5'd2);
        write_bits(16'h0001, 16);
        close_frame();
        check(arg_o[31:16] == 16'h0001, "R3 bit order", 48'(arg_o[31:16]), 48'h0001);

        // R5 commit only after the closing pulse
        g0 = go_cnt;
        send_ctrl(1'b0, 3'b101, 5'd0);
        write_bits(16'h00A5, 16);
        sen_n = 1'b1;
        repeat (4) hp();
        check(cmd_o == 16'h0042 && go_cnt == g0, "R5 no pulse yet", 48'(cmd_o), 48'h0042);
        sclk = 1'b1; hp(); sclk = 1'b0; hp();
        check(cmd_o == 16'h00A5 && go_cnt == g0 + 1, "R5 committed", 48'({8'(go_cnt - g0), cmd_o}), 48'({8'd1, 16'h00A5}));

        // R5 enable falls again before the closing pulse: pending write dropped
        g0 = go_cnt;
        send_ctrl(1'b0, 3'b101, 5'd0);
        write_bits(16'h1111, 16);
        sen_n = 1'b1; hp();
        sen_n = 1'b0; hp();
        close_frame();
        check(cmd_o == 16'h00A5 && go_cnt == g0, "R5 abort", 48'({8'(go_cnt - g0), cmd_o}), 48'h00A5);

        // R11 truncated write
        g0 = go_cnt;
        send_ctrl(1'b0, 3'b101, 5'd3);
        write_bits(16'h7E7E, 8);
        close_frame();
        check(arg_o[47:32] == 16'h8001 && go_cnt == g0, "R11 truncated", 48'(arg_o[47:32]), 48'h8001);

        // R4 release after bit 0 while enable still low
        send_ctrl(1'b1, 3'b101, 5'd8);
        read_bits(d, oe_n, oe_t);
        check(!oe_t && d == 16'hC000, "R4 turnaround", 48'({oe_t, d}), 48'h0C000);
        sclk = 1'b1; hp();
        check(sdio_oe == 1'b0, "R4 release", 48'(sdio_oe), 48'h0);
        sclk = 1'b0; hp();
        close_frame();

        // R1 clocks while idle after frames, then a clean read
        sdio = 1'b1;
        sclk = 1'b1; hp(); sclk = 1'b0; hp();
        send_ctrl(1'b1, 3'b101, 5'd1);
        read_bits(d, oe_n, oe_t);
        close_frame();
        check(d == 16'h1234 && oe_n == 16, "R1 frame start", 48'(d), 48'h1234);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule